// File: doc/BRIEF.md
# SDRAM Short-Read Sequencer

This block reads a chosen number of words from one bank and column of a single-data-rate SDRAM. The row is already open. The block starts a long read burst and cuts it short, so that only the wanted words come back. A request gives the bank, the starting column, the word count, the CAS latency (2 or 3), whether the burst should be cut with a precharge instead of a burst-terminate command, and an auto-precharge flag. A burst that was started with auto precharge cannot be cut, so the block refuses any request that has the auto-precharge flag set.

An accepted request puts a READ on the command bus. That bus then carries NOP until the cut command goes out. The cut command is placed so that the memory stops driving data right after the last wanted word. Counted from the READ edge, this slot is the same for both latencies. Counted back from the last data edge, it lies latency-minus-one cycles earlier. The block captures each returning word once the programmed latency has passed. It presents each captured word with a one-cycle valid strobe. It keeps a busy flag raised until the last wanted word has been taken.

Top module: `sdram_rd_trunc`

## Requirements
- R1: After reset the block is idle. `busy`, `rd_valid` and `req_reject` are low, `sd_cmd` is NOP (4'b0111) and `sd_dqm` is high.
- R2: A request presented while idle, with a non-zero count and no auto-precharge flag, is accepted at the next clock edge. In the following cycle `sd_cmd` is READ (4'b0101), `sd_bank` is the requested bank, `sd_addr[9:0]` is the column and `sd_addr[10]` is low. Exactly one READ is issued per accepted request.
- R3: With truncation by terminate, the command 4'b0110 is sampled by the memory exactly N edges after the READ edge, where N is the requested count. This is latency-minus-one edges before the edge at which the last wanted word is valid, for both latencies.
- R4: With truncation by precharge (`req_pre_mode` high), the command 4'b0010 takes the same slot instead. `sd_bank` equals the requested bank and `sd_addr[10]` is low, so only that bank is closed.
- R5: Exactly one truncating command is issued per request. Every other command-bus cycle of the request carries NOP.
- R6: `sd_dqm` is low from the READ cycle until the last wanted word is captured, and high while the block is idle.
- R7: Word k (k = 0 .. N-1) is sampled from `sd_dq_in` at the edge that comes CL+k edges after the READ edge. `rd_valid` is high for exactly N cycles, and `rd_data` holds the words in order. No later word is presented.
- R8: `busy` rises in the READ cycle and stays high for exactly CL+N cycles, falling at the edge that captures the last word. A request presented while busy is ignored.
- R9: A request presented while idle with `req_autopre` high or `req_count` equal to 0 is refused. `req_reject` pulses high for one cycle, no READ is issued and `busy` stays low.
- R10: `req_cl3` high selects CAS latency 3 and low selects latency 2, for that request only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_bank | input | BANK_W | Bank to read |
| req_col | input | COL_W | Starting column |
| req_count | input | CNT_W | Number of wanted words |
| req_cl3 | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| req_autopre | input | 1 | Request asks for auto precharge (refused) |
| req_pre_mode | input | 1 | Cut the burst with PRECHARGE instead of terminate |
| busy | output | 1 | Request in progress |
| req_reject | output | 1 | One-cycle pulse for a refused request |
| sd_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} command to the memory |
| sd_bank | output | BANK_W | Bank address to the memory |
| sd_addr | output | ADDR_W | Address bus to the memory |
| sd_dqm | output | 1 | Data mask, low while reading |
| sd_dq_in | input | DATA_W | Read data from the memory |
| rd_data | output | DATA_W | Captured word |
| rd_valid | output | 1 | `rd_data` holds a wanted word this cycle |

## Verification
The assertions assume that the memory's active row stays open and that no other master drives the command bus. They also assume that `req_count` is small enough that CL+N fits in the internal counter. The bench keeps within this. A behavioural memory model in the bench answers every READ with an unbounded stream that stops only at a cut command. That model is the only source of data, so the bench never gives the block a stream that breaks the latency rule. The bench keeps requests at 20 words or fewer, sets inputs only at falling edges, and releases `req_valid` after one cycle. The one exception is a deliberate poke while busy.

// File: rtl/sdrt_pkg.sv
package sdrt_pkg;
    // SDRAM command encodings as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP  = 4'b0111,
        CMD_READ = 4'b0101,
        CMD_BST  = 4'b0110,
        CMD_PRE  = 4'b0010
    } sd_cmd_e;

    // address bit carrying the auto-precharge / all-bank flag
    localparam int AP_BIT = 10;
endpackage

// File: rtl/sdrt_ctrl.sv
// Request acceptance, cycle counting and slot decisions.
module sdrt_ctrl #(
    parameter int BANK_W = 2,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              req_cl3,
    input  logic              req_autopre,
    input  logic              req_pre_mode,
    output logic              busy,
    output logic              busy_nx,
    output logic              rej,
    output logic              go_read,
    output logic              go_term,
    output logic              term_pre,
    output logic [BANK_W-1:0] term_bank,
    output logic              cap_en
);
    localparam int CW = CNT_W + 2;

    typedef struct packed {
        logic              busy;
        logic              rej;
        logic [CW-1:0]     cnt;   // cycles since READ went on the bus
        logic [CW-1:0]     num;   // wanted words
        logic [CW-1:0]     lat;   // CAS latency of this request
        logic [CW-1:0]     last;  // cnt value of the last capture
        logic              pre;
        logic [BANK_W-1:0] bank;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     accept, refuse, req_ok;
    logic [CW-1:0] lat_sel;

    always_comb begin
        st_d    = st_q;
        st_d.rej = 1'b0;
        req_ok  = !req_autopre && (req_count != '0);
        accept  = req_valid && !st_q.busy && req_ok;
        refuse  = req_valid && !st_q.busy && !req_ok;
        lat_sel = req_cl3 ? CW'(3) : CW'(2);
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.num  = CW'(req_count);
            st_d.lat  = lat_sel;
            st_d.last = lat_sel + CW'(req_count) - CW'(1);
            st_d.pre  = req_pre_mode;
            st_d.bank = req_bank;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + CW'(1);
            if (st_q.cnt == st_q.last) begin
                st_d.busy = 1'b0;
            end
        end
        if (refuse) begin
            st_d.rej = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // the cut command is set at the edge ending the cnt == N-1 cycle,
    // so the memory samples it N edges after the READ edge
    assign go_term   = st_q.busy && (st_q.cnt == st_q.num - CW'(1));
    assign cap_en    = st_q.busy && (st_q.cnt >= st_q.lat);
    assign busy      = st_q.busy;
    assign busy_nx   = st_d.busy;
    assign rej       = st_q.rej;
    assign go_read   = accept;
    assign term_pre  = st_q.pre;
    assign term_bank = st_q.bank;
endmodule

// File: rtl/sdrt_cmd_gen.sv
// Registered command, address and mask drive toward the memory.
module sdrt_cmd_gen
    import sdrt_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_read,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              go_term,
    input  logic              term_pre,
    input  logic [BANK_W-1:0] term_bank,
    input  logic              busy_nx,
    output logic [3:0]        sd_cmd,
    output logic [BANK_W-1:0] sd_bank,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_dqm
);
    typedef struct packed {
        sd_cmd_e           cmd;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic              dqm;
    } bus_st_t;

    bus_st_t bus_d, bus_q;

    always_comb begin
        bus_d      = bus_q;
        bus_d.cmd  = CMD_NOP;
        bus_d.bank = '0;
        bus_d.addr = '0;
        bus_d.dqm  = !busy_nx;
        if (go_read) begin
            bus_d.cmd               = CMD_READ;
            bus_d.bank              = rd_bank;
            bus_d.addr[COL_W-1:0]   = rd_col;
            bus_d.addr[AP_BIT]      = 1'b0;
        end else if (go_term) begin
            if (term_pre) begin
                bus_d.cmd          = CMD_PRE;
                bus_d.bank         = term_bank;
                bus_d.addr[AP_BIT] = 1'b0;
            end else begin
                bus_d.cmd = CMD_BST;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q.cmd  <= CMD_NOP;
            bus_q.bank <= '0;
            bus_q.addr <= '0;
            bus_q.dqm  <= 1'b1;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign sd_cmd  = bus_q.cmd;
    assign sd_bank = bus_q.bank;
    assign sd_addr = bus_q.addr;
    assign sd_dqm  = bus_q.dqm;
endmodule

// File: rtl/sdrt_capture.sv
// Capture register for returning read data.
module sdrt_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } cap_st_t;

    cap_st_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = cap_en;
        if (cap_en) begin
            cap_d.data = dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_data  = cap_q.data;
    assign rd_valid = cap_q.vld;
endmodule

// File: rtl/sdram_rd_trunc.sv
// Top level: issues READ, cuts the burst, captures the wanted words.
// COL_W must not exceed 10 so that address bit 10 stays free.
module sdram_rd_trunc #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              req_cl3,
    input  logic              req_autopre,
    input  logic              req_pre_mode,
    output logic              busy,
    output logic              req_reject,
    output logic [3:0]        sd_cmd,
    output logic [BANK_W-1:0] sd_bank,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_dqm,
    input  logic [DATA_W-1:0] sd_dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              busy_nx, go_read, go_term, term_pre, cap_en;
    logic [BANK_W-1:0] term_bank;

    sdrt_ctrl #(.BANK_W(BANK_W), .CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_bank(req_bank), .req_count(req_count),
        .req_cl3(req_cl3), .req_autopre(req_autopre), .req_pre_mode(req_pre_mode),
        .busy(busy), .busy_nx(busy_nx), .rej(req_reject),
        .go_read(go_read), .go_term(go_term), .term_pre(term_pre),
        .term_bank(term_bank), .cap_en(cap_en)
    );

    sdrt_cmd_gen #(.BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) cmd_i (
        .clk(clk), .rst_n(rst_n),
        .go_read(go_read), .rd_bank(req_bank), .rd_col(req_col),
        .go_term(go_term), .term_pre(term_pre), .term_bank(term_bank),
        .busy_nx(busy_nx),
        .sd_cmd(sd_cmd), .sd_bank(sd_bank), .sd_addr(sd_addr), .sd_dqm(sd_dqm)
    );

    sdrt_capture #(.DATA_W(DATA_W)) cap_i (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .dq_in(sd_dq_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/sdrt_chk.sv
module sdrt_chk
    import sdrt_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              req_reject,
    input logic              rd_valid,
    input logic              sd_dqm,
    input logic [3:0]        sd_cmd,
    input logic [ADDR_W-1:0] sd_addr
);
    logic       is_term;
    logic [1:0] tc_q;

    assign is_term = (sd_cmd == CMD_BST) || (sd_cmd == CMD_PRE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q <= 2'd0;
        end else if (sd_cmd == CMD_READ) begin
            tc_q <= 2'd0;
        end else if (is_term && tc_q != 2'd3) begin
            tc_q <= tc_q + 2'd1;
        end
    end

    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_NOP || sd_cmd == CMD_READ || sd_cmd == CMD_BST || sd_cmd == CMD_PRE)); // R5
    AST_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        is_term |-> (tc_q == 2'd0)); // R5
    AST_READ_NO_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_READ) |-> !sd_addr[AP_BIT]); // R2
    AST_READ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_READ) |-> (busy && !$past(busy))); // R8
    AST_READ_DQM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_READ) |-> !sd_dqm); // R6
    AST_REJECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> (sd_cmd != CMD_READ && !busy)); // R9
    AST_VALID_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(busy)); // R7
endmodule

bind sdram_rd_trunc sdrt_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .req_reject(req_reject),
    .rd_valid(rd_valid), .sd_dqm(sd_dqm), .sd_cmd(sd_cmd), .sd_addr(sd_addr)
);

// File: tb/sdram_rd_trunc_tb_top.sv
`timescale 1ns/1ps
module sdram_rd_trunc_tb_top;
    localparam logic [3:0] NOP = 4'b0111, RD = 4'b0101, BST = 4'b0110, PRE = 4'b0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [9:0]  req_col = '0;
    logic [9:0]  req_count = '0;
    logic        req_cl3 = 1'b0, req_autopre = 1'b0, req_pre_mode = 1'b0;
    logic        busy, req_reject, sd_dqm, rd_valid;
    logic [3:0]  sd_cmd;
    logic [1:0]  sd_bank;
    logic [12:0] sd_addr;
    logic [15:0] dq = 16'hDEAD;
    logic [15:0] rd_data;

    always #10 clk = ~clk;

    sdram_rd_trunc dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_col(req_col), .req_count(req_count), .req_cl3(req_cl3),
        .req_autopre(req_autopre), .req_pre_mode(req_pre_mode),
        .busy(busy), .req_reject(req_reject), .sd_cmd(sd_cmd), .sd_bank(sd_bank),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_in(dq),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int total = 0, bad = 0;
    bit done = 0;
    logic [15:0] sbq[$];
    int exp_n = 1, exp_cl = 2, exp_bank = 0, exp_col = 0;
    bit exp_pre = 0;
    int reads_seen = 0, terms_seen = 0;
    bit dqm_bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input int b, input int c, input int k);
        return 16'((c + k) * 5 + b * 1111 + 7);
    endfunction

    // memory model: answers READ with an endless stream, stopped by a cut command
    int m_t = 0, m_last = -1, m_bank = 0, m_col = 0;
    bit m_act = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0;
            dq <= 16'hDEAD;
        end else begin
            if (sd_cmd == BST || sd_cmd == PRE) terms_seen++;
            if (sd_cmd == RD) begin
                m_act = 1; m_t = 0; m_last = -1;
                m_bank = int'(sd_bank); m_col = int'(sd_addr[9:0]);
                reads_seen++;
                chk(sd_addr[10] == 1'b0, "R2 READ addr bit10", sd_addr[10], 0);
                chk(m_bank == exp_bank, "R2 READ bank", m_bank, exp_bank);
                chk(m_col == exp_col, "R2 READ column", m_col, exp_col);
                chk(!sd_dqm, "R6 dqm at READ", sd_dqm, 0);
            end else if (m_act) begin
                m_t++;
                if (sd_cmd == BST || sd_cmd == PRE) begin
                    chk(m_t == exp_n, "R3 cut slot after READ", m_t, exp_n);
                    if (exp_pre) begin
                        chk(sd_cmd == PRE, "R4 cut command", sd_cmd, PRE);
                        chk(int'(sd_bank) == exp_bank && !sd_addr[10], "R4 precharge bank/bit10",
                            {sd_addr[10], sd_bank}, exp_bank);
                    end else begin
                        chk(sd_cmd == BST, "R3 cut command", sd_cmd, BST);
                    end
                    m_last = m_t - 1;
                end else if (sd_cmd != NOP) begin
                    chk(0, "R5 non-NOP filler", sd_cmd, NOP);
                end
            end
            begin
                int k;
                k = m_t + 1 - exp_cl;
                if (m_act && k >= 0 && (m_last < 0 || k <= m_last))
                    dq <= word_of(m_bank, m_col, k);
                else
                    dq <= 16'hDEAD;
                if (m_act && m_last >= 0 && k > m_last) m_act = 0;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && sd_dqm) dqm_bad = 1;
            if (rd_valid) begin
                if (sbq.size() == 0) begin
                    chk(0, "R7 extra word", rd_data, 0);
                end else begin
                    logic [15:0] e;
                    e = sbq.pop_front();
                    chk(rd_data == e, "R7 word value", rd_data, e);
                end
            end
        end
    end

    task automatic run_req(input int b, input int c, input int n, input bit cl3,
                           input bit pre, input bit poke);
        int r0, t0, cyc;
        @(negedge clk);
        exp_n = n; exp_cl = cl3 ? 3 : 2; exp_bank = b; exp_col = c; exp_pre = pre;
        r0 = reads_seen; t0 = terms_seen; dqm_bad = 0;
        for (int k = 0; k < n; k++) sbq.push_back(word_of(b, c, k));
        req_bank = 2'(b); req_col = 10'(c); req_count = 10'(n);
        req_cl3 = cl3; req_pre_mode = pre; req_autopre = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy rises", busy, 1);
        cyc = 0;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 1) begin
                req_col = 10'(c + 99); req_count = 10'(n + 3); req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
        end
        chk(cyc == exp_cl + n, "R8 R10 busy length", cyc, exp_cl + n);
        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R7 all words delivered", sbq.size(), 0);
        chk(reads_seen - r0 == 1, "R2 R8 one READ", reads_seen - r0, 1);
        chk(terms_seen - t0 == 1, "R5 one cut command", terms_seen - t0, 1);
        chk(!dqm_bad, "R6 dqm low while busy", dqm_bad, 0);
        chk(sd_dqm == 1'b1, "R6 dqm high when idle", sd_dqm, 1);
    endtask

    task automatic reject_req(input bit ap, input int n);
        int r0;
        @(negedge clk);
        r0 = reads_seen;
        req_bank = 2'd1; req_col = 10'h55; req_count = 10'(n);
        req_autopre = ap; req_cl3 = 1'b0; req_pre_mode = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_autopre = 1'b0;
        chk(req_reject == 1'b1, "R9 reject pulse", req_reject, 1);
        chk(busy == 1'b0, "R9 stays idle", busy, 0);
        @(negedge clk);
        chk(req_reject == 1'b0, "R9 pulse one cycle", req_reject, 0);
        repeat (3) @(negedge clk);
        chk(reads_seen == r0, "R9 no READ", reads_seen - r0, 0);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R9 no activity", {busy, rd_valid}, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(sd_cmd == NOP, "R1 cmd", sd_cmd, NOP);
        chk(sd_dqm == 1'b1, "R1 dqm", sd_dqm, 1);
        chk(rd_valid == 1'b0 && req_reject == 1'b0, "R1 valid/reject", {rd_valid, req_reject}, 0);

        run_req(1, 10'h040, 1, 1'b0, 1'b0, 1'b0);   // R3 R10 N=1 CL2
        run_req(2, 10'h100, 1, 1'b1, 1'b0, 1'b0);   // R3 R10 N=1 CL3
        run_req(0, 10'h3F0, 4, 1'b0, 1'b0, 1'b0);   // R7 CL2
        run_req(3, 10'h011, 4, 1'b1, 1'b0, 1'b0);   // R7 CL3
        run_req(1, 10'h200, 7, 1'b1, 1'b1, 1'b0);   // R4 CL3
        run_req(2, 10'h0A5, 3, 1'b0, 1'b1, 1'b0);   // R4 CL2
        run_req(0, 10'h300, 20, 1'b1, 1'b0, 1'b0);  // R7 long
        run_req(3, 10'h123, 5, 1'b0, 1'b0, 1'b1);   // R8 poke while busy
        reject_req(1'b1, 4);                         // R9 auto precharge
        reject_req(1'b0, 0);                         // R9 zero count
        run_req(1, 10'h005, 2, 1'b0, 1'b0, 1'b0);   // recovery after reject
        finish_run();
    end
endmodule